// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is a bidirectional general-purpose I/O port of parameterised width (eight bits by default). Software reaches it through a small register bus with three registers. The first is an output latch. The second holds one drive-mode bit per pin, which selects sink-only open-drain drive or push-pull drive for that pin. The third is a read-only view of the live pin levels. The latch is read back from its own address, so reading the latch never returns the pin state.

Every bit can also carry an output from an on-chip peripheral. When a bit's alternate enable is set, the peripheral's output is ANDed with the latch bit. With the latch held at 1, the peripheral alone sets the pin. The sampled pin levels pass through a synchroniser and go both to the pin register and to the peripherals' inputs. In low-power stop mode, all drivers are released unless the output-enable control is set. The pads are modelled as separate drive-enable, drive-value and input signals.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and right after it, the latch reads 0xFF, the mode register reads 0x00 and every pin_oe bit is 0, so all pins are released.
- R2: A write with wr_en high at address 0 loads wdata into the latch on the next rising clock edge. Reading address 0 returns the latch contents combinationally.
- R3: A write at address 1 loads the mode register, and reading address 1 returns it. A mode bit of 0 selects open-drain drive and a mode bit of 1 selects push-pull drive.
- R4: Reading address 2 returns the pin levels as they stood two rising clock edges earlier. A pin change is not visible after only one edge.
- R5: Address 2 is read-only. A write to it changes neither the latch nor the mode register.
- R6: Reading address 3 returns 0x00, and a write to address 3 changes no register.
- R7: The effective output of a bit is its latch bit ANDed with af_out when af_en is 1 for that bit. When af_en is 0, the effective output is the latch bit alone.
- R8: In open-drain mode, an effective output of 0 gives pin_oe=1 and pin_do=0, and an effective output of 1 gives pin_oe=0. pin_do is never 1 in open-drain mode.
- R9: In push-pull mode, pin_oe=1 and pin_do equals the effective output.
- R10: af_in presents the same two-edge-synchronised pin levels as the pin register.
- R11: When stop is 1 and stop_oe is 0, every pin_oe bit is 0 whatever the latch and mode hold. When stop_oe is 1, drive is unchanged by stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (2) | Register address |
| wr_en | input | 1 | Write strobe, single cycle |
| wdata | input | WIDTH (8) | Write data |
| rdata | output | WIDTH (8) | Read data for addr, combinational |
| af_en | input | WIDTH (8) | Per-bit alternate-output enable |
| af_out | input | WIDTH (8) | Peripheral output values |
| af_in | output | WIDTH (8) | Synchronised pin levels for peripherals |
| stop | input | 1 | Low-power stop mode active |
| stop_oe | input | 1 | Keep drivers enabled during stop |
| pin_in | input | WIDTH (8) | Sampled pad levels |
| pin_oe | output | WIDTH (8) | Pad drive enable |
| pin_do | output | WIDTH (8) | Pad drive value |

## Verification
A corrupted latch or mode bit shows at pin_oe and pin_do within the same cycle, because the pad logic is combinational from those registers. A wrong synchroniser stage shows as pin data that appears one edge early or late, both in the pin register and on af_in. The bench samples both sides of the second edge to catch this. A decode fault shows on a read-back of the latch and mode registers taken straight after a write to the read-only or unmapped address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_LATCH = 2'd1,
      SEL_MODE  = 2'd2,
      SEL_PINS  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d_in;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_out = chain[STAGES-1];

   if (STAGES == 2) begin : g_chk
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         warm <= '0;
         else if (warm != 2) warm <= warm + 2'd1;
      end
      // R4
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2) |-> (q_out == $past(d_in, 2)));
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int                WIDTH      = 8,
   parameter int                ADDR_W     = 2,
   parameter logic [ADDR_W-1:0] ADDR_LATCH = 0,
   parameter logic [ADDR_W-1:0] ADDR_MODE  = 1,
   parameter logic [ADDR_W-1:0] ADDR_PINS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  pins_sync,
   output logic [WIDTH-1:0]  rdata,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  mode_q
);
   localparam logic [WIDTH-1:0] LATCH_RST = '1;
   localparam logic [WIDTH-1:0] MODE_RST  = '0;

   if (ADDR_LATCH == ADDR_MODE || ADDR_LATCH == ADDR_PINS || ADDR_MODE == ADDR_PINS)
   begin : g_bad_map
      $error("gpio_regs: register addresses must be distinct");
   end

   reg_sel_e sel;

   always_comb begin
      if (addr == ADDR_LATCH)     sel = SEL_LATCH;
      else if (addr == ADDR_MODE) sel = SEL_MODE;
      else if (addr == ADDR_PINS) sel = SEL_PINS;
      else                        sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= LATCH_RST;
         mode_q  <= MODE_RST;
      end else if (wr_en) begin
         if (sel == SEL_LATCH) latch_q <= wdata;
         if (sel == SEL_MODE)  mode_q  <= wdata;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_LATCH: rdata = latch_q;
         SEL_MODE:  rdata = mode_q;
         SEL_PINS:  rdata = pins_sync;
         default:   rdata = '0;
      endcase
   end

   // R2
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_LATCH) |=> (latch_q == $past(wdata)));
   // R3
   mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_MODE) |=> (mode_q == $past(wdata)));
   // R5
   pins_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_PINS) |=> ($stable(latch_q) && $stable(mode_q)));
   // R6
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (rdata == '0));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] mode_q,
   input  logic [WIDTH-1:0] af_en,
   input  logic [WIDTH-1:0] af_out,
   input  logic             stop,
   input  logic             stop_oe,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_do
);
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_pad_ctl: WIDTH must be positive");
   end

   logic release_all;
   assign release_all = stop & ~stop_oe;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic eff;
      logic drive;
      assign eff = latch_q[b] & (af_en[b] ? af_out[b] : 1'b1);
      always_comb begin
         if (mode_q[b]) begin
            drive     = 1'b1;
            pin_do[b] = eff;
         end else begin
            drive     = ~eff;
            pin_do[b] = 1'b0;
         end
         pin_oe[b] = drive & ~release_all;
      end
   end

   // R8
   od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_do & ~mode_q) == '0));
   // R11
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !stop_oe) |-> (pin_oe == '0));
   // R9
   pp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop || stop_oe) |-> ((pin_oe & mode_q) == mode_q));
   // R7
   latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_do & ~latch_q) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int                WIDTH       = 8,
   parameter int                ADDR_W      = 2,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_LATCH  = 0,
   parameter logic [ADDR_W-1:0] ADDR_MODE   = 1,
   parameter logic [ADDR_W-1:0] ADDR_PINS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   input  logic [WIDTH-1:0]  af_en,
   input  logic [WIDTH-1:0]  af_out,
   output logic [WIDTH-1:0]  af_in,
   input  logic              stop,
   input  logic              stop_oe,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_do
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("gpio_port: ADDR_W must hold three register addresses");
   end

   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] mode_q;

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pins_sync)
   );

   gpio_regs #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W),
      .ADDR_LATCH(ADDR_LATCH), .ADDR_MODE(ADDR_MODE), .ADDR_PINS(ADDR_PINS)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .pins_sync (pins_sync),
      .rdata     (rdata),
      .latch_q   (latch_q),
      .mode_q    (mode_q)
   );

   gpio_pad_ctl #(.WIDTH(WIDTH)) i_pad (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch_q (latch_q),
      .mode_q  (mode_q),
      .af_en   (af_en),
      .af_out  (af_out),
      .stop    (stop),
      .stop_oe (stop_oe),
      .pin_oe  (pin_oe),
      .pin_do  (pin_do)
   );

   assign af_in = pins_sync;

   // R10
   af_in_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_PINS) |-> (af_in == rdata));
   // R1
   reset_release_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] af_en = '0;
   logic [7:0] af_out = '0;
   logic [7:0] af_in;
   logic       stop = 1'b0;
   logic       stop_oe = 1'b0;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe;
   logic [7:0] pin_do;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_port i_gpio_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .af_en(af_en), .af_out(af_out), .af_in(af_in),
      .stop(stop), .stop_oe(stop_oe), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_do(pin_do)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%02h expected=%02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   // expected pad values from latch, mode and alternate inputs
   function automatic logic [7:0] exp_eff(input logic [7:0] l);
      return l & ((af_en & af_out) | ~af_en);
   endfunction
   function automatic logic [7:0] exp_oe(input logic [7:0] l, input logic [7:0] m);
      logic [7:0] e = exp_eff(l);
      if (stop && !stop_oe) return 8'h00;
      return m | (~m & ~e);
   endfunction
   function automatic logic [7:0] exp_do(input logic [7:0] l, input logic [7:0] m);
      return m & exp_eff(l);
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      #1 check("R1 oe during reset", pin_oe, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      rd(2'd0, d); check("R1 latch reset", d, 8'hFF);
      rd(2'd1, d); check("R1 mode reset", d, 8'h00);
      check("R1 oe after reset", pin_oe, 8'h00);
   endtask

   task automatic t_latch();
      logic [7:0] d;
      wr(2'd0, 8'hA5); rd(2'd0, d); check("R2 latch A5", d, 8'hA5);
      wr(2'd0, 8'h3C); rd(2'd0, d); check("R2 latch 3C", d, 8'h3C);
   endtask

   task automatic t_mode();
      logic [7:0] d;
      wr(2'd1, 8'h5A); rd(2'd1, d); check("R3 mode 5A", d, 8'h5A);
   endtask

   task automatic t_readonly();
      logic [7:0] d;
      wr(2'd0, 8'h96); wr(2'd1, 8'h0F);
      wr(2'd2, 8'h00);
      rd(2'd0, d); check("R5 latch kept", d, 8'h96);
      rd(2'd1, d); check("R5 mode kept", d, 8'h0F);
      wr(2'd3, 8'h11);
      rd(2'd3, d); check("R6 unmapped read", d, 8'h00);
      rd(2'd0, d); check("R6 latch kept", d, 8'h96);
      rd(2'd1, d); check("R6 mode kept", d, 8'h0F);
   endtask

   task automatic t_pins();
      logic [7:0] d;
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      addr = 2'd2;
      pin_in = 8'hC3;
      @(negedge clk); #1;
      check("R4 one edge old", rdata, 8'h00);
      check("R10 one edge old", af_in, 8'h00);
      @(negedge clk); #1;
      check("R4 two edges", rdata, 8'hC3);
      check("R10 two edges", af_in, 8'hC3);
      pin_in = 8'h5E;
      repeat (2) @(negedge clk);
      rd(2'd2, d); check("R4 second pattern", d, 8'h5E);
   endtask

   task automatic t_od();
      wr(2'd1, 8'h00); wr(2'd0, 8'hF0);
      #1 check("R8 od oe", pin_oe, 8'h0F);
      check("R8 od do", pin_do, 8'h00);
      wr(2'd0, 8'hFF);
      #1 check("R8 od released", pin_oe, 8'h00);
   endtask

   task automatic t_pp();
      wr(2'd1, 8'hFF); wr(2'd0, 8'h69);
      #1 check("R9 pp oe", pin_oe, 8'hFF);
      check("R9 pp do", pin_do, 8'h69);
      wr(2'd1, 8'hF0); wr(2'd0, 8'h3C);
      #1 check("R9 mixed oe", pin_oe, exp_oe(8'h3C, 8'hF0));
      check("R9 mixed do", pin_do, exp_do(8'h3C, 8'hF0));
   endtask

   task automatic t_alt();
      wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
      @(negedge clk); af_en = 8'h0F; af_out = 8'h05;
      #1 check("R7 af pp do", pin_do, 8'hF5);
      wr(2'd0, 8'hEE);
      #1 check("R7 af latch and", pin_do, exp_do(8'hEE, 8'hFF));
      wr(2'd1, 8'h00); wr(2'd0, 8'hFF);
      #1 check("R7 af od oe", pin_oe, 8'h0A);
      @(negedge clk); af_en = 8'h00; af_out = 8'h00;
      #1 check("R7 af disabled", pin_oe, 8'h00);
   endtask

   task automatic t_stop();
      wr(2'd1, 8'hCC); wr(2'd0, 8'h0F);
      @(negedge clk); stop = 1'b1; stop_oe = 1'b0;
      #1 check("R11 stop released", pin_oe, 8'h00);
      @(negedge clk); stop_oe = 1'b1;
      #1 check("R11 stop keep oe", pin_oe, exp_oe(8'h0F, 8'hCC));
      check("R11 stop keep do", pin_do, exp_do(8'h0F, 8'hCC));
      @(negedge clk); stop = 1'b0; stop_oe = 1'b0;
      #1 check("R11 stop exit", pin_oe, exp_oe(8'h0F, 8'hCC));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_latch();
      t_mode();
      t_readonly();
      t_pins();
      t_od();
      t_pp();
      t_alt();
      t_stop();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog got=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule